// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block produces the external bus waveforms of a processor's instruction fetch machine cycle. On a start request it puts the program counter on the address bus and drives the fetch strobe. It then drives the memory request and read strobes for the read, and captures the opcode from the data bus. The read phase can be stretched by any number of wait states. The last two clock states of the cycle hold a dynamic memory refresh slot. In that slot the address bus carries a refresh row from an internal counter and the memory request strobe pulses with read kept inactive.

The block runs from a clock at twice the bus clock rate. A free-running phase bit splits every bus clock state into a first half, which begins on the bus rising edge, and a second half, which begins on the bus falling edge. Every half-clock event therefore lands on a plain rising edge of the fast clock. All strobes are active low.

Top module: `fetch_cycle_seq`

## Requirements
- R1: After reset the fetch, memory request, read and refresh strobes are all high, the done output is low and no cycle runs until a start request.
- R2: In the first half of T1 the address bus carries the captured program counter and the fetch strobe is low, while memory request and read are still high. The fetch strobe stays low until the bus rising edge that begins T3.
- R3: Memory request and read go low at the bus falling edge inside T1 and stay low through T2 and every wait state. Both return high on the rising edge that begins T3.
- R4: The active-low wait input is sampled on the bus falling edge in T2 and in each wait state. Every low sample adds exactly one more wait state, with no upper bound.
- R5: The opcode output takes the data bus value present at the rising edge that begins T3, which is the last edge at which read is low. The output holds that value until the next fetch.
- R6: Throughout T3 and T4 the refresh strobe is low, read stays high and the address bus carries {page input[7:0], 1'b0, refresh counter[6:0]} on a 16-bit bus.
- R7: In the refresh slot memory request goes low at the bus falling edge in T3 and high at the bus falling edge in T4, and the address does not change while it is low.
- R8: The 7-bit refresh counter starts at 0 after reset and advances by one when each fetch ends, so 127 is followed by 0.
- R9: Done is high for exactly one half-clock right after T4 ends. A start request held from that point is taken at the next bus rising edge, so T1 begins two fast-clock cycles after done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two periods per bus clock state |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Fetch request, sampled at a bus rising edge while idle |
| pc_i | input | ADDR_W (16) | Program counter to fetch from |
| page_i | input | PAGE_W (8) | Upper refresh address bits |
| wait_n_i | input | 1 | Active-low wait request |
| data_i | input | DATA_W (8) | Memory data bus |
| addr_o | output | ADDR_W (16) | Address bus |
| m1_n_o | output | 1 | Active-low fetch cycle strobe |
| mreq_n_o | output | 1 | Active-low memory request |
| rd_n_o | output | 1 | Active-low read strobe |
| rfsh_n_o | output | 1 | Active-low refresh strobe |
| opcode_o | output | DATA_W (8) | Captured opcode |
| done_o | output | 1 | One half-clock pulse at the end of the cycle |

## Verification
The bench holds the correct opcode on the data bus only during the half-clock before T3 begins, so a design that latches one edge early or late reads the inverted byte. It drives zero, one, three and five wait states and releases the wait input just before the final sample. A design that samples on the wrong edge, or counts wait states off by one, puts read and fetch strobe transitions in the wrong half-clock. More than 128 back-to-back fetches carry the refresh counter through its wrap, which exposes a counter of the wrong width or with the wrong step. Every half-clock of the refresh slot is compared as well, which catches a memory request pulse that opens before the refresh address is stable or a read asserted during refresh.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
   typedef enum logic [2:0] {
      FS_IDLE = 3'd0,
      FS_T1   = 3'd1,
      FS_T2   = 3'd2,
      FS_TW   = 3'd3,
      FS_T3   = 3'd4,
      FS_T4   = 3'd5
   } fetch_state_e;
endpackage

// File: rtl/fetch_seq_timer.sv
module fetch_seq_timer
   import fetch_seq_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         wait_n_i,
   output fetch_state_e state_o,
   output logic         half_o,
   output logic         launch_o,
   output logic         capture_o,
   output logic         finish_o,
   output logic         done_o
);
   fetch_state_e state_q, state_d;
   logic half_q;
   logic wait_q;
   logic done_q;
   logic stretch_slot;

   // second half of a bus state means the next fast edge is a bus rising edge
   assign stretch_slot = (state_q == FS_T2) || (state_q == FS_TW);
   assign launch_o     = (state_q == FS_IDLE) && half_q && start_i;
   assign capture_o    = stretch_slot && half_q && !wait_q;
   assign finish_o     = (state_q == FS_T4) && half_q;

   always_comb begin
      state_d = state_q;
      if (half_q) begin
         case (state_q)
            FS_IDLE: if (start_i) state_d = FS_T1;
            FS_T1:   state_d = FS_T2;
            FS_T2,
            FS_TW:   state_d = wait_q ? FS_TW : FS_T3;
            FS_T3:   state_d = FS_T4;
            FS_T4:   state_d = FS_IDLE;
            default: state_d = FS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         half_q  <= 1'b0;
         wait_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         half_q  <= !half_q;
         done_q  <= finish_o;
         // wait sampled on the bus falling edge of T2 and of each wait state
         if (stretch_slot && !half_q) begin
            wait_q <= !wait_n_i;
         end
      end
   end

   assign state_o = state_q;
   assign half_o  = half_q;
   assign done_o  = done_q;

   assert_wait_entry_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_TW && !half_q) |-> $past(wait_q));
   assert_done_single_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_t1_from_idle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == FS_T1) |-> $past(state_q == FS_IDLE && start_i));
endmodule

// File: rtl/fetch_refresh_ctr.sv
module fetch_refresh_ctr #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   assert_ctr_step_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |=> (cnt_o == $past(cnt_o) + 1'b1));
   assert_ctr_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/fetch_bus_decode.sv
module fetch_bus_decode
   import fetch_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8,
   parameter int RFSH_W = 7
) (
   input  fetch_state_e      state_i,
   input  logic              half_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [RFSH_W-1:0] row_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              m1_n_o,
   output logic              mreq_n_o,
   output logic              rd_n_o,
   output logic              rfsh_n_o
);
   localparam int PAD_W = ADDR_W - PAGE_W - RFSH_W;

   logic [ADDR_W-1:0] rfsh_addr;

   generate
      if (PAD_W > 0) begin : g_pad
         assign rfsh_addr = {page_i, {PAD_W{1'b0}}, row_i};
      end else begin : g_nopad
         assign rfsh_addr = {page_i, row_i};
      end
   endgenerate

   always_comb begin
      addr_o   = pc_i;
      m1_n_o   = 1'b1;
      mreq_n_o = 1'b1;
      rd_n_o   = 1'b1;
      rfsh_n_o = 1'b1;
      case (state_i)
         FS_T1: begin
            m1_n_o   = 1'b0;
            mreq_n_o = !half_i;
            rd_n_o   = !half_i;
         end
         FS_T2, FS_TW: begin
            m1_n_o   = 1'b0;
            mreq_n_o = 1'b0;
            rd_n_o   = 1'b0;
         end
         FS_T3: begin
            addr_o   = rfsh_addr;
            rfsh_n_o = 1'b0;
            mreq_n_o = !half_i;
         end
         FS_T4: begin
            addr_o   = rfsh_addr;
            rfsh_n_o = 1'b0;
            mreq_n_o = half_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/fetch_cycle_seq.sv
module fetch_cycle_seq
   import fetch_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 8,
   parameter int RFSH_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              wait_n_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              m1_n_o,
   output logic              mreq_n_o,
   output logic              rd_n_o,
   output logic              rfsh_n_o,
   output logic [DATA_W-1:0] opcode_o,
   output logic              done_o
);
   generate
      if (RFSH_W < 1 || DATA_W < 1 || ADDR_W < PAGE_W + RFSH_W) begin : g_bad_params
         $error("fetch_cycle_seq: address bus too narrow for page and refresh row");
      end
   endgenerate

   fetch_state_e      state;
   logic              half;
   logic              launch;
   logic              capture;
   logic              finish;
   logic [RFSH_W-1:0] row;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] opcode_q;

   fetch_seq_timer i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .wait_n_i  (wait_n_i),
      .state_o   (state),
      .half_o    (half),
      .launch_o  (launch),
      .capture_o (capture),
      .finish_o  (finish),
      .done_o    (done_o)
   );

   fetch_refresh_ctr #(.CNT_W(RFSH_W)) i_row_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (finish),
      .cnt_o (row)
   );

   fetch_bus_decode #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .RFSH_W (RFSH_W)
   ) i_decode (
      .state_i  (state),
      .half_i   (half),
      .pc_i     (pc_q),
      .page_i   (page_i),
      .row_i    (row),
      .addr_o   (addr_o),
      .m1_n_o   (m1_n_o),
      .mreq_n_o (mreq_n_o),
      .rd_n_o   (rd_n_o),
      .rfsh_n_o (rfsh_n_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         opcode_q <= '0;
      end else begin
         if (launch) pc_q <= pc_i;
         // the T3 rising edge latches data while read is still low
         if (capture) opcode_q <= data_i;
      end
   end

   assign opcode_o = opcode_q;

   assert_no_read_in_refresh_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n_o |-> rd_n_o);
   assert_read_inside_request_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> (!mreq_n_o && !m1_n_o));
   assert_refresh_addr_stable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n_o && !rfsh_n_o) |=> (mreq_n_o || $stable(addr_o)));
   assert_opcode_under_read_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(opcode_o) |-> $past(!rd_n_o));
endmodule

// File: tb/test_fetch_cycle_seq.sv
module test_fetch_cycle_seq;
   typedef struct packed {
      logic [15:0] addr;
      logic        m1;
      logic        mreq;
      logic        rd;
      logic        rf;
      logic        done;
      logic [7:0]  op;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] pc_i = '0;
   logic [7:0]  page_i = '0;
   logic        wait_n_i = 1'b1;
   logic [7:0]  data_i = '0;
   logic [15:0] addr_o;
   logic        m1_n_o, mreq_n_o, rd_n_o, rfsh_n_o, done_o;
   logic [7:0]  opcode_o;

   exp_t sb_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   row_model = 0;
   bit   tracking = 1'b0;

   always #2 clk = ~clk;

   fetch_cycle_seq i_fetch_cycle_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .pc_i     (pc_i),
      .page_i   (page_i),
      .wait_n_i (wait_n_i),
      .data_i   (data_i),
      .addr_o   (addr_o),
      .m1_n_o   (m1_n_o),
      .mreq_n_o (mreq_n_o),
      .rd_n_o   (rd_n_o),
      .rfsh_n_o (rfsh_n_o),
      .opcode_o (opcode_o),
      .done_o   (done_o)
   );

   task automatic tally(input bit ok, input string msg);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", msg);
      end
   endtask

   function automatic exp_t mk(input logic [15:0] a, input logic m1, input logic mq,
                               input logic rd, input logic rf, input logic dn,
                               input logic [7:0] op);
      exp_t e;
      e.addr = a; e.m1 = m1; e.mreq = mq; e.rd = rd; e.rf = rf; e.done = dn; e.op = op;
      return e;
   endfunction

   // monitor: compares one expected half-clock per falling fast edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (!tracking && sb_q.size() > 0 && !m1_n_o) tracking = 1'b1;
         if (tracking) begin
            exp_t e;
            string req;
            bit ok;
            e = sb_q.pop_front();
            if (e.done)       req = "R5 R9";
            else if (!e.rf)   req = "R6 R7 R8";
            else if (e.mreq)  req = "R2";
            else              req = "R3 R4";
            ok = (addr_o === e.addr) && (m1_n_o === e.m1) && (mreq_n_o === e.mreq) &&
                 (rd_n_o === e.rd) && (rfsh_n_o === e.rf) && (done_o === e.done);
            if (e.done) ok = ok && (opcode_o === e.op);
            tally(ok, $sformatf("%s act addr=%h m1=%b mreq=%b rd=%b rfsh=%b done=%b op=%h exp addr=%h m1=%b mreq=%b rd=%b rfsh=%b done=%b op=%h",
               req, addr_o, m1_n_o, mreq_n_o, rd_n_o, rfsh_n_o, done_o, opcode_o,
               e.addr, e.m1, e.mreq, e.rd, e.rf, e.done, e.op));
            if (e.done) tracking = 1'b0;
         end
      end
   end

   // driver: pushes the expected waveform, then stimulates one fetch
   task automatic run_fetch(input logic [15:0] pc, input logic [7:0] op,
                            input logic [7:0] pg, input int nw, input bit b2b);
      logic [15:0] ra;
      int lat;
      ra = {pg, 1'b0, row_model[6:0]};
      sb_q.push_back(mk(pc, 0, 1, 1, 1, 0, 8'h00));
      sb_q.push_back(mk(pc, 0, 0, 0, 1, 0, 8'h00));
      for (int h = 0; h < 2 + 2 * nw; h++) sb_q.push_back(mk(pc, 0, 0, 0, 1, 0, 8'h00));
      sb_q.push_back(mk(ra, 1, 1, 1, 0, 0, 8'h00));
      sb_q.push_back(mk(ra, 1, 0, 1, 0, 0, 8'h00));
      sb_q.push_back(mk(ra, 1, 0, 1, 0, 0, 8'h00));
      sb_q.push_back(mk(ra, 1, 1, 1, 0, 0, 8'h00));
      sb_q.push_back(mk(pc, 1, 1, 1, 1, 1, op));
      row_model = (row_model + 1) % 128; // R8 wrap model
      pc_i = pc; page_i = pg; data_i = ~op; start_i = 1'b1; lat = 0;
      forever begin
         @(negedge clk);
         lat++;
         if (!m1_n_o) break;
      end
      if (b2b) tally(lat == 2, $sformatf("R9 start latency act=%0d exp=2", lat));
      start_i = 1'b0;
      wait_n_i = (nw == 0);
      for (int k = 1; k <= 4 + 2 * nw; k++) begin
         @(negedge clk);
         if (k == 2 + 2 * nw) wait_n_i = 1'b1;
         if (k == 3 + 2 * nw) data_i = op;
         if (k == 4 + 2 * nw) data_i = ~op;
      end
      forever begin
         @(negedge clk);
         if (done_o) break;
      end
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired act=hung exp=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      tally(m1_n_o && mreq_n_o && rd_n_o && rfsh_n_o && !done_o,
            $sformatf("R1 in reset act=%b%b%b%b done=%b exp=1111 done=0",
                      m1_n_o, mreq_n_o, rd_n_o, rfsh_n_o, done_o));
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      tally(m1_n_o && mreq_n_o && rd_n_o && rfsh_n_o && !done_o,
            $sformatf("R1 idle after reset act=%b%b%b%b done=%b exp=1111 done=0",
                      m1_n_o, mreq_n_o, rd_n_o, rfsh_n_o, done_o));
      // R2 R3 R5: no waits, then R4 with one, three and five wait states
      run_fetch(16'h1234, 8'hA5, 8'h3C, 0, 1'b0);
      run_fetch(16'hBEEF, 8'h5A, 8'hC3, 1, 1'b1);
      run_fetch(16'h0F0F, 8'h81, 8'h00, 3, 1'b1);
      run_fetch(16'hFFFF, 8'h7E, 8'hFF, 0, 1'b1);
      run_fetch(16'h8000, 8'h01, 8'h55, 5, 1'b1);
      // R8: enough back-to-back fetches to wrap the refresh row
      for (int i = 0; i < 130; i++) begin
         run_fetch(16'(i * 16'h0137), 8'(i * 7 + 3), 8'(i), i % 3, 1'b1);
      end
      repeat (4) @(negedge clk);
      tally(sb_q.size() == 0, $sformatf("R9 scoreboard drained act=%0d exp=0", sb_q.size()));
      finish_run();
   end
endmodule